// File: doc/BRIEF.md
# External Interrupt Level Selector

This block sits beside a processor's trap logic and keeps its pending trap index current with respect to fifteen external interrupt levels. Each clock it registers the incoming level vector, finds the highest pending level and turns it into an external-interrupt trap code. It then raises or withdraws a level-sensitive hard-interrupt request toward the core.

The index register is shared with synchronous traps. The core can load a synchronous trap code into it. The selector never overwrites or clears a code that is not an external interrupt. The trap-entry logic zeroes the index with a clear pulse once it has taken the trap. If levels are still pending, the selector picks them up again on the following cycle.

Top module: `ext_irq_level_sel`

## Requirements
- R1: While reset is high, and on the first cycle after it, `trap_idx` is 0x00 and `hard_req` is 0.
- R2: Among bits 15 down to 1 of `lvl_i`, the highest set bit wins, and `trap_idx` becomes 0x10 ORed with that bit number (0x11 to 0x1F). Bit 0 of `lvl_i` has no effect.
- R3: A change on `lvl_i` reaches `trap_idx` on the second rising edge after it is applied, and not on the first.
- R4: A level update happens only when `trap_idx` is 0x00 or its upper nibble is 0x1. Any other index is neither replaced nor cleared by the level logic.
- R5: `hard_req` goes to 1 when the level logic writes an index that differs from the current one. It keeps its value while the selected index stays the same. Whenever it is 1, `trap_idx` is in 0x11 to 0x1F.
- R6: When no level in bits 15 to 1 is pending and `trap_idx` has upper nibble 0x1, the next edge sets `trap_idx` to 0x00 and `hard_req` to 0.
- R7: A high `clr_i` sets `trap_idx` to 0x00 and `hard_req` to 0 on the next edge. It wins over the level logic in that cycle. If levels are still pending, they are selected again on the edge after.
- R8: A high `sync_load_i` loads `sync_code_i` into `trap_idx` and sets `hard_req` to 0 on the next edge. It wins over both `clr_i` and the level logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lvl_i | input | 16 | Pending external levels; bits 15..1 used, bit 0 ignored |
| sync_load_i | input | 1 | Load a synchronous trap code this cycle |
| sync_code_i | input | 8 | Synchronous trap code to load |
| clr_i | input | 1 | Trap taken; zero the index |
| trap_idx | output | 8 | Current pending trap index |
| hard_req | output | 1 | Hard-interrupt request toward the core |

## Verification
A clear from trap entry can land in the same cycle as a level update that would otherwise rewrite the index. A synchronous load can also coincide with a clear. The bench holds a level pending and pulses the load and the clear together. It then pulses the clear alone. After each edge it checks that the load won over the clear, and that the clear won over the level logic for exactly one cycle. The pending level is then expected to return on the edge after the clear.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int unsigned IDX_W_D    = 8;
  localparam int unsigned LVL_W_D    = 16;
  localparam int unsigned EXT_BASE_D = 8'h10;

  typedef enum logic [2:0] {
    UPD_HOLD,
    UPD_SYNC,
    UPD_CLR,
    UPD_EXT,
    UPD_DROP
  } upd_e;
endpackage

// File: rtl/irqsel_lvl_reg.sv
module irqsel_lvl_reg #(
  parameter int unsigned LVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] lvl_q
);
  localparam logic [LVL_W-1:0] BIT0_MASK = LVL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_i & ~BIT0_MASK;
  end
endmodule

// File: rtl/irqsel_prio_enc.sv
module irqsel_prio_enc #(
  parameter int unsigned LVL_W    = 16,
  parameter int unsigned LVL_BITS = $clog2(LVL_W)
) (
  input  logic [LVL_W-1:0]    lvl,
  output logic                any,
  output logic [LVL_BITS-1:0] top
);
  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = 1; i < LVL_W; i++) begin
      if (lvl[i]) begin
        any = 1'b1;
        top = LVL_BITS'(i);
      end
    end
  end
endmodule

// File: rtl/irqsel_idx_ctrl.sv
module irqsel_idx_ctrl
  import irqsel_pkg::*;
#(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned LVL_BITS = 4,
  parameter int unsigned EXT_BASE = 8'h10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_load,
  input  logic [IDX_W-1:0]    sync_code,
  input  logic                clr,
  input  logic                any,
  input  logic [LVL_BITS-1:0] top,
  output logic [IDX_W-1:0]    idx,
  output logic                req
);
  localparam int unsigned HI_W = IDX_W - LVL_BITS;
  localparam logic [HI_W-1:0] EXT_HI = HI_W'(EXT_BASE >> LVL_BITS);

  logic             idx_is_ext;
  logic             idx_empty;
  logic [IDX_W-1:0] cand;
  upd_e             upd;

  assign idx_is_ext = (idx[IDX_W-1:LVL_BITS] == EXT_HI);
  assign idx_empty  = (idx == '0);
  assign cand       = {EXT_HI, top};

  always_comb begin
    if (sync_load)                                upd = UPD_SYNC;
    else if (clr)                                 upd = UPD_CLR;
    else if (any && (idx_empty || idx_is_ext))    upd = (cand != idx) ? UPD_EXT : UPD_HOLD;
    else if (!any && idx_is_ext)                  upd = UPD_DROP;
    else                                          upd = UPD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      req <= 1'b0;
    end else begin
      case (upd)
        UPD_SYNC: begin idx <= sync_code; req <= 1'b0; end
        UPD_CLR:  begin idx <= '0;        req <= 1'b0; end
        UPD_EXT:  begin idx <= cand;      req <= 1'b1; end
        UPD_DROP: begin idx <= '0;        req <= 1'b0; end
        default:  begin idx <= idx;       req <= req;  end
      endcase
    end
  end
endmodule

// File: rtl/ext_irq_level_sel.sv
module ext_irq_level_sel
  import irqsel_pkg::*;
#(
  parameter int unsigned IDX_W    = IDX_W_D,
  parameter int unsigned LVL_W    = LVL_W_D,
  parameter int unsigned EXT_BASE = EXT_BASE_D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             sync_load_i,
  input  logic [IDX_W-1:0] sync_code_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] trap_idx,
  output logic             hard_req
);
  localparam int unsigned LVL_BITS = $clog2(LVL_W);

  logic [LVL_W-1:0]    lvl_q;
  logic                lvl_any;
  logic [LVL_BITS-1:0] lvl_top;

  irqsel_lvl_reg #(.LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst(rst), .lvl_i(lvl_i), .lvl_q(lvl_q)
  );

  irqsel_prio_enc #(.LVL_W(LVL_W), .LVL_BITS(LVL_BITS)) u_enc (
    .lvl(lvl_q), .any(lvl_any), .top(lvl_top)
  );

  irqsel_idx_ctrl #(.IDX_W(IDX_W), .LVL_BITS(LVL_BITS), .EXT_BASE(EXT_BASE)) u_ctl (
    .clk(clk), .rst(rst),
    .sync_load(sync_load_i), .sync_code(sync_code_i), .clr(clr_i),
    .any(lvl_any), .top(lvl_top),
    .idx(trap_idx), .req(hard_req)
  );
endmodule

// File: rtl/ext_irq_level_sel_chk.sv
module ext_irq_level_sel_chk #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned LVL_W    = 16,
  parameter int unsigned EXT_BASE = 8'h10
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] lvl_i,
  input logic             sync_load_i,
  input logic [IDX_W-1:0] sync_code_i,
  input logic             clr_i,
  input logic [IDX_W-1:0] trap_idx,
  input logic             hard_req
);
  localparam int unsigned LB   = $clog2(LVL_W);
  localparam int unsigned HI_W = IDX_W - LB;
  localparam logic [HI_W-1:0] EXT_HI = HI_W'(EXT_BASE >> LB);

  logic is_ext;
  assign is_ext = (trap_idx[IDX_W-1:LB] == EXT_HI);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (trap_idx == '0 && !hard_req));

  a_r4_foreign_kept: assert property (@(posedge clk) disable iff (rst)
    (trap_idx != '0 && !is_ext && !sync_load_i && !clr_i) |=> $stable(trap_idx));

  a_r5_req_means_ext: assert property (@(posedge clk) disable iff (rst)
    hard_req |-> (is_ext && trap_idx[LB-1:0] != '0));

  a_r6_drop_when_idle: assert property (@(posedge clk) disable iff (rst)
    (is_ext && $past(lvl_i[LVL_W-1:1]) == '0 && !sync_load_i && !clr_i)
    |=> (trap_idx == '0 && !hard_req));

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !sync_load_i) |=> (trap_idx == '0 && !hard_req));

  a_r8_sync_load: assert property (@(posedge clk) disable iff (rst)
    sync_load_i |=> (trap_idx == $past(sync_code_i) && !hard_req));
endmodule

bind ext_irq_level_sel ext_irq_level_sel_chk #(
  .IDX_W(IDX_W), .LVL_W(LVL_W), .EXT_BASE(EXT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .lvl_i(lvl_i), .sync_load_i(sync_load_i),
  .sync_code_i(sync_code_i), .clr_i(clr_i), .trap_idx(trap_idx),
  .hard_req(hard_req)
);

// File: tb/ext_irq_level_sel_test.sv
module ext_irq_level_sel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] lvl = '0;
  logic        sld = 1'b0;
  logic [7:0]  scode = '0;
  logic        clr = 1'b0;
  logic [7:0]  trap_idx;
  logic        hard_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ext_irq_level_sel uut (
    .clk(clk), .rst(rst), .lvl_i(lvl), .sync_load_i(sld),
    .sync_code_i(scode), .clr_i(clr), .trap_idx(trap_idx), .hard_req(hard_req)
  );

  // {lvl, sync_load, sync_code, clr, expected idx, expected req}
  localparam int NV = 13;
  localparam logic [34:0] VEC [NV] = '{
    {16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R1 idle
    {16'h0001, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R2 bit 0 ignored
    {16'h0024, 1'b0, 8'h00, 1'b0, 8'h15, 1'b1},  // R2 level 5 over 2
    {16'h8024, 1'b0, 8'h00, 1'b0, 8'h1F, 1'b1},  // R2 level 15
    {16'h0002, 1'b0, 8'h00, 1'b0, 8'h11, 1'b1},  // R2 level 1
    {16'h0000, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R6 drop
    {16'h0010, 1'b1, 8'h2A, 1'b0, 8'h2A, 1'b0},  // R4 foreign not replaced
    {16'h0000, 1'b0, 8'h00, 1'b0, 8'h2A, 1'b0},  // R4 foreign not cleared
    {16'h0008, 1'b0, 8'h00, 1'b1, 8'h13, 1'b1},  // R7 clear then level 3
    {16'h0008, 1'b1, 8'h05, 1'b0, 8'h05, 1'b0},  // R8 sync load
    {16'h0000, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0},  // R7 clear
    {16'h4000, 1'b0, 8'h00, 1'b0, 8'h1E, 1'b1},  // R2 level 14
    {16'hFFFF, 1'b0, 8'h00, 1'b0, 8'h1F, 1'b1}   // R2 all set
  };

  task automatic chk(input string req, input logic [7:0] eidx, input logic ereq);
    checks++;
    if (trap_idx !== eidx || hard_req !== ereq) begin
      fails++;
      $display("FAIL %s: actual idx=%02h req=%b expected idx=%02h req=%b",
               req, trap_idx, hard_req, eidx, ereq);
    end
  endtask

  task automatic step(input logic [15:0] l, input logic s, input logic [7:0] c,
                      input logic cl);
    @(negedge clk);
    lvl = l; sld = s; scode = c; clr = cl;
    @(posedge clk);
    @(negedge clk);
    sld = 1'b0; clr = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1-watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", 8'h00, 1'b0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 chk("R1 after reset", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][34:19], VEC[i][18], VEC[i][17:10], VEC[i][9]);
      chk($sformatf("vector %0d (R2/R4/R6/R7/R8)", i), VEC[i][8:1], VEC[i][0]);
    end

    // R1: reset mid-run
    @(negedge clk) begin rst = 1'b1; lvl = '0; end
    @(posedge clk); #1 chk("R1 mid-run reset", 8'h00, 1'b0);
    @(negedge clk) rst = 1'b0;

    // R3: two-edge latency
    @(negedge clk) lvl = 16'h0200;
    @(posedge clk); #1 chk("R3 first edge", 8'h00, 1'b0);
    @(posedge clk); #1 chk("R3 second edge", 8'h19, 1'b1);

    // R5: same top level keeps index and request
    step(16'h0300, 1'b0, 8'h00, 1'b0);
    chk("R5 hold", 8'h19, 1'b1);

    // R8 and R7 collisions with a pending level
    @(negedge clk) begin sld = 1'b1; scode = 8'h33; clr = 1'b1; end
    @(posedge clk); #1 chk("R8 load over clear", 8'h33, 1'b0);
    @(negedge clk) begin sld = 1'b0; clr = 1'b0; end
    @(posedge clk); #1 chk("R4 level blocked by foreign", 8'h33, 1'b0);
    @(negedge clk) clr = 1'b1;
    @(posedge clk); #1 chk("R7 clear over level", 8'h00, 1'b0);
    @(negedge clk) clr = 1'b0;
    @(posedge clk); #1 chk("R7 reselect", 8'h19, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule